// File: doc/BRIEF.md
# Seconds Watchdog With Reset Pulse

This block is a watchdog counter that counts down once per selected tick, normally a 1 Hz strobe. Software arms it by writing an 8-bit timeout to the value register and keeps it alive by writing that register again before the count runs out. Writing zero stops it. A separate strobe tells the block that the status register has been read by the bus logic, and that read clears the count, which also stops the watchdog.

When a running count reaches zero on a tick, the block sets a sticky expiry flag. If the reset enable bit is set, it also drives an active-low reset output for a fixed number of system clocks. After expiry the counter stays at zero until software loads it again.

The block has a small register port with three registers: status at address 0, control at address 1 and count value at address 2. Reads are combinational. Timeouts from 2 to 255 ticks are meaningful, and software conventionally reloads 60. Refreshes are expected no closer than half a second apart. That spacing is a rule for software and is not checked in hardware.

Top module: `sec_watchdog`

## Requirements
- R1: A write of a non-zero byte to address 2 loads the count with that byte, and reading address 2 returns the current count.
- R2: A write of 0 to address 2 stops the watchdog. Later ticks leave the count at 0 and cause no expiry.
- R3: The count decreases by one only on a pulse of `tick_in[sel]`, where `sel` is control bits 1:0. The value 2'b10 selects `tick_in[2]`, the 1 Hz strobe. Pulses on the other tick inputs have no effect.
- R4: A pulse on `stat_rd` clears the count to 0 on the next clock edge. It takes priority over a value write in the same cycle.
- R5: A selected tick while the count is 1 makes the count 0 and sets the expiry flag. The flag is bit 6 of address 0 and also appears on `wd_flag`. The count then stays 0 on later ticks.
- R6: Writing address 0 with bit 6 clear clears the flag. Writing it with bit 6 set leaves the flag unchanged. Clearing the flag does not reload the count.
- R7: If control bit 7 is 1 at expiry, `rst_out_n` goes low on the expiry clock edge and stays low for exactly RST_CYCLES clocks.
- R8: If control bit 7 is 0 at expiry, `rst_out_n` stays high.
- R9: After reset the count, the flag and the control register are 0, and `rst_out_n` is high.
- R10: A value write in the same cycle as a selected tick loads the written value and ignores the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 4 | One-clock tick strobes, one per selectable source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 control, 2 value) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| stat_rd | input | 1 | Strobe marking a status read; clears the count |
| wd_flag | output | 1 | Sticky expiry flag |
| rst_out_n | output | 1 | Active-low reset pulse on expiry |

## Verification
The countdown is driven with ticks on both the selected and the unselected sources. This separates correct source decoding from a counter that responds to any tick. Loads, zero writes and status-read strobes are applied alone and also in the same cycle as ticks or writes, which shows the priority between them. Expiry is run once with the reset output enabled and once with it disabled. The low pulse is measured clock by clock, which catches a pulse that is off by one cycle or fires when it is disabled. Flag writes with bit 6 set and with bit 6 clear then show that the flag is sticky and that clearing it leaves the counter stopped.

// File: rtl/sec_watchdog.sv
module sec_watchdog #(
  parameter int RST_CYCLES = 4,
  localparam int PW = $clog2(RST_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tick_in,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       stat_rd,
  output logic       wd_flag,
  output logic       rst_out_n
);

  logic [7:0]    cnt_q;
  logic [7:0]    ctl_q;
  logic          flag_q;
  logic [PW-1:0] pulse_q;

  wire tick    = tick_in[ctl_q[1:0]];
  wire wr_stat = reg_we && (reg_addr == 2'd0);
  wire wr_ctl  = reg_we && (reg_addr == 2'd1);
  wire wr_val  = reg_we && (reg_addr == 2'd2);
  wire expire  = tick && (cnt_q == 8'd1) && !wr_val && !stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (stat_rd)              cnt_q <= '0;
    else if (wr_val)               cnt_q <= reg_wdata;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag_q <= 1'b0;
    else if (expire)                  flag_q <= 1'b1;
    else if (wr_stat && !reg_wdata[6]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pulse_q <= '0;
    else if (expire && ctl_q[7]) pulse_q <= PW'(RST_CYCLES);
    else if (pulse_q != '0)      pulse_q <= pulse_q - PW'(1);
  end

  assign wd_flag   = flag_q;
  assign rst_out_n = (pulse_q == '0);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {1'b0, flag_q, 6'b0};
      2'd1:    reg_rdata = ctl_q;
      2'd2:    reg_rdata = cnt_q;
      default: reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/sec_watchdog_chk.sv
module sec_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       stat_rd,
  input logic       wd_flag,
  input logic       rst_out_n,
  input logic [7:0] cnt_q,
  input logic [7:0] ctl_q
);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> cnt_q == 8'd0);

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2 && !stat_rd) |=> cnt_q == $past(reg_wdata));

  a_r2_stopped_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 8'd0 && !reg_we && !stat_rd) |=> cnt_q == 8'd0);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !(reg_we && reg_addr == 2'd0 && !reg_wdata[6])) |=> wd_flag);

  a_r7_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> (wd_flag && cnt_q == 8'd0));

  a_r8_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> $past(ctl_q[7]));

endmodule

bind sec_watchdog sec_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .stat_rd(stat_rd), .wd_flag(wd_flag),
  .rst_out_n(rst_out_n), .cnt_q(cnt_q), .ctl_q(ctl_q)
);

// File: tb/sec_watchdog_tb.sv
module sec_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC = 4;
  localparam int NV = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tick_in = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       stat_rd = 1'b0;
  logic       wd_flag;
  logic       rst_out_n;

  int n_chk = 0;
  int n_fail = 0;

  sec_watchdog #(.RST_CYCLES(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stat_rd(stat_rd), .wd_flag(wd_flag), .rst_out_n(rst_out_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {we, addr, wdata, stat_rd, tick, chk_addr, expected}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 2'd2, 8'd5,   1'b0, 4'h0, 2'd2, 8'd5},    // R1 load
    {1'b0, 2'd0, 8'd0,   1'b0, 4'h1, 2'd2, 8'd4},    // R3 selected src 0
    {1'b0, 2'd0, 8'd0,   1'b0, 4'h4, 2'd2, 8'd4},    // R3 unselected src 2
    {1'b1, 2'd1, 8'h82,  1'b0, 4'h0, 2'd1, 8'h82},   // R3 select 1 Hz, reset enable
    {1'b0, 2'd0, 8'd0,   1'b0, 4'h1, 2'd2, 8'd4},    // R3 src 0 now ignored
    {1'b0, 2'd0, 8'd0,   1'b0, 4'h4, 2'd2, 8'd3},    // R3 src 2 counts
    {1'b1, 2'd2, 8'd0,   1'b0, 4'h0, 2'd2, 8'd0},    // R2 stop
    {1'b0, 2'd0, 8'd0,   1'b0, 4'h4, 2'd2, 8'd0},    // R2 tick while stopped
    {1'b0, 2'd0, 8'd0,   1'b0, 4'h4, 2'd0, 8'h00},   // R2 no expiry flag
    {1'b1, 2'd2, 8'd7,   1'b0, 4'h4, 2'd2, 8'd7},    // R10 write beats tick
    {1'b1, 2'd2, 8'd9,   1'b1, 4'h0, 2'd2, 8'd0},    // R4 read beats write
    {1'b1, 2'd2, 8'd9,   1'b0, 4'h0, 2'd2, 8'd9},    // R1 reload
    {1'b0, 2'd0, 8'd0,   1'b1, 4'h0, 2'd2, 8'd0},    // R4 read clears
    {1'b0, 2'd0, 8'd0,   1'b0, 4'h4, 2'd2, 8'd0}     // R4 stays stopped
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic rd, input logic [3:0] t);
    reg_we = we; reg_addr = a; reg_wdata = d; stat_rd = rd; tick_in = t;
    @(posedge clk);
    #1;
    reg_we = 1'b0; stat_rd = 1'b0; tick_in = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    reg_addr = 2'd2; #1 check("R9 count", reg_rdata, 8'd0);
    reg_addr = 2'd1; #1 check("R9 control", reg_rdata, 8'd0);
    check("R9 flag/rst", {6'b0, wd_flag, rst_out_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][25], VEC[i][24:23], VEC[i][22:15], VEC[i][14], VEC[i][13:10]);
      reg_addr = VEC[i][9:8];
      #1 check($sformatf("vector %0d", i), reg_rdata, VEC[i][7:0]);
    end

    // R5/R7 expiry with reset enabled (control still 0x82)
    step(1'b1, 2'd2, 8'd2, 1'b0, 4'h0);
    step(1'b0, 2'd0, 8'd0, 1'b0, 4'h4);
    reg_addr = 2'd2; #1 check("R5 count at 1", reg_rdata, 8'd1);
    check("R7 no pulse yet", {7'b0, rst_out_n}, 8'd1);
    step(1'b0, 2'd0, 8'd0, 1'b0, 4'h4);
    for (int k = 0; k < RST_CYC; k++) begin
      check("R7 pulse low", {7'b0, rst_out_n}, 8'd0);
      @(negedge clk);
    end
    check("R7 pulse ends", {7'b0, rst_out_n}, 8'd1);
    reg_addr = 2'd0; #1 check("R5 flag bit6", reg_rdata, 8'h40);
    step(1'b0, 2'd0, 8'd0, 1'b0, 4'h4);
    reg_addr = 2'd2; #1 check("R5 stays stopped", reg_rdata, 8'd0);

    // R6 flag clear
    step(1'b1, 2'd0, 8'h40, 1'b0, 4'h0);
    check("R6 write 1 keeps flag", {7'b0, wd_flag}, 8'd1);
    step(1'b1, 2'd0, 8'h00, 1'b0, 4'h0);
    check("R6 write 0 clears flag", {7'b0, wd_flag}, 8'd0);
    reg_addr = 2'd2; #1 check("R6 no restart", reg_rdata, 8'd0);

    // R8 expiry with reset disabled
    step(1'b1, 2'd1, 8'h02, 1'b0, 4'h0);
    step(1'b1, 2'd2, 8'd2, 1'b0, 4'h0);
    step(1'b0, 2'd0, 8'd0, 1'b0, 4'h4);
    step(1'b0, 2'd0, 8'd0, 1'b0, 4'h4);
    check("R8 flag set", {7'b0, wd_flag}, 8'd1);
    for (int k = 0; k < RST_CYC; k++) begin
      check("R8 reset stays high", {7'b0, rst_out_n}, 8'd1);
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule